// File: doc/BRIEF.md
# Four-Lane Skew-Aligning Clock-Crossing FIFO

This block gathers pixel words from four sensor readout banks. Each bank has its own source-synchronous clock, and the four clocks are skewed against one another. Each lane writes into a private dual-clock FIFO in its own clock domain. All four FIFOs are drained together in a single internal clock domain, so every output word holds exactly one entry from each lane. Entries written with the same index on every lane therefore leave the block side by side, whatever the skew between the banks.

Each lane has its own bring-up sequencer. While the lane's write clock is stopped, the lane stays quiet. Once the clock is seen toggling, the sequencer asks the write side to reset its half of the FIFO. It then waits until a minimum number of cycles has passed in both the read domain and the write domain. After that it releases the lane and reports it as up. The lane accepts words only after this handshake has finished, so the FIFO is always reset before use.

The output is a valid/ready stream. A word moves on a read-clock edge where `m_valid` and `m_ready` are both high. While `m_ready` is low, the block holds the current word unchanged and the FIFOs keep filling. When a FIFO is full, further writes to that lane are lost and a sticky flag records the loss.

Top module: `lane_align_fifo`

## Requirements
- R1: While `rd_rst_n` is low, and just after it is released, `lane_up` is 0, `m_valid` is 0 and `overflow` is 0. Reset also clears a previously set `overflow`.
- R2: A lane's `lane_up` bit rises only after that lane's write clock has been seen toggling. A lane whose clock is stopped stays down while the other lanes come up.
- R3: The per-lane FIFO reset request is held for at least `MIN_RST` (default 5) read-clock cycles and at least `MIN_RST` write-clock cycles. The lane is reported up only after the request has been withdrawn. As a result, `lane_up` stays low for at least 5 read cycles after the lane's clock starts.
- R4: Once a lane is up, it stays up until `rd_rst_n` is asserted.
- R5: `m_valid` is high only when all four lanes are up and none of the four FIFOs is empty. It falls in the same read cycle that any FIFO becomes empty, so surplus data on one lane never produces an output word.
- R6: `m_data` carries one 16-bit entry per lane, with lane 0 in bits [15:0], lane 1 in [31:16], lane 2 in [47:32] and lane 3 in [63:48]. The k-th output word holds the k-th accepted entry of every lane.
- R7: A word is consumed only on a read edge where `m_valid` and `m_ready` are both high. While `m_ready` is low and `m_valid` is high, `m_valid` stays high and `m_data` stays stable.
- R8: Each lane holds up to 16 entries. A write to a full lane is discarded and sets `overflow`. `overflow` then stays high until `rd_rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 4 | Source-synchronous write clock of each lane |
| wr_valid | input | 4 | Per-lane write strobe, sampled on that lane's clock |
| wr_data | input | 64 | Per-lane write word, lane i at bits [16i+15:16i] |
| rd_clk | input | 1 | Internal read clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset for the whole block |
| m_valid | output | 1 | Aligned output word available |
| m_ready | input | 1 | Downstream accepts the word |
| m_data | output | 64 | Aligned output word |
| lane_up | output | 4 | Lane has finished its reset handshake |
| overflow | output | 1 | Sticky: a write hit a full lane |

## Verification
The assertions check on every read cycle that the output is never valid with a lane down, that a stalled word holds both its valid and its data, that lanes stay up and overflow stays set once raised, and that every reset request lasted the minimum read-domain length before it dropped. Other behaviours cover several clock domains or depend on data order, and only the bench scenarios can show them. These are: the word-by-word alignment across four unrelated write clocks, a lane with a stopped clock staying down, valid dropping exactly when the shortest lane runs dry with surplus data on another lane, and the loss of the seventeenth word into a full lane.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
  typedef enum logic [1:0] {
    LS_DETECT = 2'd0,
    LS_ASSERT = 2'd1,
    LS_DRAIN  = 2'd2,
    LS_UP     = 2'd3
  } lane_state_e;
endpackage

// File: rtl/lane_sync.sv
module lane_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lane_clk_reset.sv
module lane_clk_reset
  import lane_align_pkg::*;
#(
  parameter int unsigned MIN_RST = 5
) (
  input  logic wr_clk,
  input  logic rd_clk,
  input  logic rd_rst_n,
  output logic wr_clr,
  output logic wr_live,
  output logic rd_req,
  output logic rd_up
);
  localparam int unsigned CW = $clog2(MIN_RST + 1);
  localparam logic [CW-1:0] CNT_END = CW'(MIN_RST);

  // write domain: activity toggle, request sync, reset counter
  logic          tog;
  logic          req_w;
  logic [CW-1:0] wcnt;
  logic          wdone;

  always_ff @(posedge wr_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) tog <= 1'b0;
    else           tog <= ~tog;
  end

  lane_sync #(.W(1)) u_req_sync (
    .clk(wr_clk), .rst_n(rd_rst_n), .d(rd_req), .q(req_w)
  );

  always_ff @(posedge wr_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      wcnt    <= '0;
      wdone   <= 1'b0;
      wr_live <= 1'b0;
    end else if (req_w) begin
      wr_live <= 1'b0;
      if (wcnt != CNT_END) wcnt <= wcnt + 1'b1;
      wdone <= (wcnt == CNT_END);
    end else begin
      wcnt  <= '0;
      wdone <= 1'b0;
      if (wdone) wr_live <= 1'b1;
    end
  end

  assign wr_clr = req_w;

  // read domain: detect toggling, drive the handshake
  logic          tog_r, tog_d, done_r;
  logic [1:0]    edges;
  logic [CW-1:0] rcnt;
  lane_state_e   st;

  lane_sync #(.W(1)) u_tog_sync (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(tog), .q(tog_r)
  );
  lane_sync #(.W(1)) u_done_sync (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wdone), .q(done_r)
  );

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      tog_d  <= 1'b0;
      edges  <= '0;
      rcnt   <= '0;
      rd_req <= 1'b0;
      st     <= LS_DETECT;
    end else begin
      tog_d <= tog_r;
      unique case (st)
        LS_DETECT: begin
          if (tog_r ^ tog_d) edges <= edges + 1'b1;
          if (edges == 2'd2) begin
            st     <= LS_ASSERT;
            rd_req <= 1'b1;
            rcnt   <= '0;
          end
        end
        LS_ASSERT: begin
          if (rcnt != CNT_END) rcnt <= rcnt + 1'b1;
          if (rcnt == CNT_END && done_r) begin
            st     <= LS_DRAIN;
            rd_req <= 1'b0;
          end
        end
        LS_DRAIN: if (!done_r) st <= LS_UP;
        LS_UP:    st <= LS_UP;
        default:  st <= LS_DETECT;
      endcase
    end
  end

  assign rd_up = (st == LS_UP);
endmodule

// File: rtl/lane_async_fifo.sv
module lane_async_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic          arst_n,
  input  logic          wr_clk,
  input  logic          wr_clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ovf,
  input  logic          rd_clk,
  input  logic          rd_clr,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wbin, wgray, rbin, rgray, rg_w, wg_r;
  logic [AW:0]   wbin_nx, rbin_nx;
  logic          full, push;

  lane_sync #(.W(AW+1)) u_rg_sync (
    .clk(wr_clk), .rst_n(arst_n), .d(rgray), .q(rg_w)
  );
  lane_sync #(.W(AW+1)) u_wg_sync (
    .clk(rd_clk), .rst_n(arst_n), .d(wgray), .q(wg_r)
  );

  assign full    = (wgray == {~rg_w[AW:AW-1], rg_w[AW-2:0]});
  assign push    = wr_en && !full;
  assign wbin_nx = wbin + 1'b1;
  assign rbin_nx = rbin + 1'b1;

  always_ff @(posedge wr_clk) begin
    if (push) mem[wbin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge wr_clk or negedge arst_n) begin
    if (!arst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      wr_ovf <= 1'b0;
    end else if (wr_clr) begin
      wbin   <= '0;
      wgray  <= '0;
      wr_ovf <= 1'b0;
    end else begin
      if (push) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      if (wr_en && full) wr_ovf <= 1'b1;
    end
  end

  always_ff @(posedge rd_clk or negedge arst_n) begin
    if (!arst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_clr) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_en) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  assign rd_empty = (rgray == wg_r);
  assign rd_data  = mem[rbin[AW-1:0]];
endmodule

// File: rtl/lane_align_fifo.sv
module lane_align_fifo #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned DW      = 16,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned MIN_RST = 5
) (
  input  logic [LANES-1:0]    wr_clk,
  input  logic [LANES-1:0]    wr_valid,
  input  logic [LANES*DW-1:0] wr_data,
  input  logic                rd_clk,
  input  logic                rd_rst_n,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [LANES*DW-1:0] m_data,
  output logic [LANES-1:0]    lane_up,
  output logic                overflow
);
  logic [LANES-1:0] lane_req, empty, ovf_w, ovf_r;
  logic             rd_en;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic wclr, wlive;

    lane_clk_reset #(.MIN_RST(MIN_RST)) u_ctl (
      .wr_clk  (wr_clk[i]),
      .rd_clk  (rd_clk),
      .rd_rst_n(rd_rst_n),
      .wr_clr  (wclr),
      .wr_live (wlive),
      .rd_req  (lane_req[i]),
      .rd_up   (lane_up[i])
    );

    lane_async_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .arst_n  (rd_rst_n),
      .wr_clk  (wr_clk[i]),
      .wr_clr  (wclr),
      .wr_en   (wr_valid[i] && wlive),
      .wr_data (wr_data[i*DW +: DW]),
      .wr_ovf  (ovf_w[i]),
      .rd_clk  (rd_clk),
      .rd_clr  (!lane_up[i]),
      .rd_en   (rd_en),
      .rd_data (m_data[i*DW +: DW]),
      .rd_empty(empty[i])
    );

    lane_sync #(.W(1)) u_ovf_sync (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(ovf_w[i]), .q(ovf_r[i])
    );
  end

  assign m_valid = (&lane_up) && !(|empty);
  assign rd_en   = m_valid && m_ready;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n)    overflow <= 1'b0;
    else if (|ovf_r)  overflow <= 1'b1;
  end
endmodule

// File: rtl/lane_align_chk.sv
module lane_align_chk #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned DW      = 16,
  parameter int unsigned MIN_RST = 5
) (
  input logic                rd_clk,
  input logic                rd_rst_n,
  input logic                m_valid,
  input logic                m_ready,
  input logic [LANES*DW-1:0] m_data,
  input logic [LANES-1:0]    lane_up,
  input logic                overflow,
  input logic [LANES-1:0]    lane_req
);
  // R5
  valid_needs_up_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    m_valid |-> (&lane_up));

  // R7
  stall_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R8
  ovf_sticky_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    overflow |=> overflow);

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    logic [7:0] hold_cnt;

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n)          hold_cnt <= '0;
      else if (!lane_req[i])  hold_cnt <= '0;
      else if (hold_cnt != 8'hFF) hold_cnt <= hold_cnt + 1'b1;
    end

    // R4
    up_sticky_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      lane_up[i] |=> lane_up[i]);

    // R3
    rst_len_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $fell(lane_req[i]) |-> (hold_cnt >= 8'(MIN_RST)));

    // R3
    up_after_req_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      lane_up[i] |-> !lane_req[i]);
  end
endmodule

bind lane_align_fifo lane_align_chk #(
  .LANES(LANES), .DW(DW), .MIN_RST(MIN_RST)
) u_chk (
  .rd_clk  (rd_clk),
  .rd_rst_n(rd_rst_n),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data),
  .lane_up (lane_up),
  .overflow(overflow),
  .lane_req(lane_req)
);

// File: tb/tb_lane_align_fifo.sv
`timescale 1ns/1ps
module tb_lane_align_fifo;
  logic [3:0]  wclk = '0;
  logic [3:0]  clk_en = 4'b0111;
  logic [3:0]  wv = '0;
  logic [63:0] wd = '0;
  logic        rd_clk = 1'b0;
  logic        rd_rst_n = 1'b0;
  logic        m_ready = 1'b0;
  logic        m_valid, overflow;
  logic [63:0] m_data;
  logic [3:0]  lane_up;

  int checks = 0;
  int fails  = 0;
  int pops   = 0;
  int seqv [4];
  logic [15:0] q0[$], q1[$], q2[$], q3[$];

  lane_align_fifo dut (
    .wr_clk(wclk), .wr_valid(wv), .wr_data(wd),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .lane_up(lane_up), .overflow(overflow)
  );

  always #2.5 rd_clk = ~rd_clk;
  always #4.5 if (clk_en[0]) wclk[0] = ~wclk[0];
  always #5.5 if (clk_en[1]) wclk[1] = ~wclk[1];
  always #6.5 if (clk_en[2]) wclk[2] = ~wclk[2];
  always #7.0 if (clk_en[3]) wclk[3] = ~wclk[3];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_exp(input int ln, input logic [15:0] v);
    case (ln)
      0: q0.push_back(v);
      1: q1.push_back(v);
      2: q2.push_back(v);
      default: q3.push_back(v);
    endcase
  endtask

  // driver: n writes on lane ln, only the first keep are expected to survive
  task automatic wr_burst(input int ln, input int n, input int keep);
    for (int k = 0; k < n; k++) begin
      logic [15:0] v;
      @(negedge wclk[ln]);
      v = {ln[1:0], seqv[ln][13:0]};
      wv[ln] = 1'b1;
      wd[ln*16 +: 16] = v;
      if (k < keep) push_exp(ln, v);
      seqv[ln]++;
    end
    @(negedge wclk[ln]);
    wv[ln] = 1'b0;
  endtask

  task automatic rd_cycles(input int n);
    for (int k = 0; k < n; k++) @(posedge rd_clk);
    #1;
  endtask

  // monitor: compare every transferred word with the scoreboard
  always @(negedge rd_clk) begin
    if (rd_rst_n && m_valid && m_ready) begin
      if (q0.size() == 0 || q1.size() == 0 || q2.size() == 0 || q3.size() == 0) begin
        chk(1'b0, "R5 word with an empty lane", {63'd0, m_valid}, 64'd0);
      end else begin
        logic [63:0] e;
        e = {q3.pop_front(), q2.pop_front(), q1.pop_front(), q0.pop_front()};
        chk(m_data == e, "R6 aligned word", m_data, e);
      end
      pops++;
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base;
    logic [63:0] held;
    for (int i = 0; i < 4; i++) seqv[i] = 0;

    #20;
    chk(lane_up == 4'h0 && !m_valid && !overflow, "R1 in reset", {lane_up, m_valid, overflow}, 64'd0);
    #30 rd_rst_n = 1'b1;
    #10;
    chk(lane_up == 4'h0 && !m_valid && !overflow, "R1 after release", {lane_up, m_valid, overflow}, 64'd0);

    #840; // t=900: lane 3 clock still stopped
    chk(lane_up == 4'b0111, "R2 stopped lane stays down", lane_up, 64'h7);
    #100 clk_en[3] = 1'b1;
    #25;
    chk(lane_up[3] == 1'b0, "R3 minimum reset time", lane_up, 64'h7);
    for (int k = 0; k < 1000 && lane_up != 4'hF; k++) @(posedge rd_clk);
    #1;
    chk(lane_up == 4'hF, "R2 lane up after clock starts", lane_up, 64'hF);

    // streaming with ready held high
    m_ready = 1'b1;
    base = pops;
    fork
      wr_burst(0, 20, 20);
      wr_burst(1, 20, 20);
      wr_burst(2, 20, 20);
      wr_burst(3, 20, 20);
    join
    rd_cycles(100);
    chk(pops - base == 20, "R6 word count", pops - base, 20);
    chk(!m_valid, "R5 valid low when drained", m_valid, 0);

    // unequal fill: lane 3 has surplus
    base = pops;
    fork
      wr_burst(0, 3, 3);
      wr_burst(1, 3, 3);
      wr_burst(2, 3, 3);
      wr_burst(3, 5, 5);
    join
    rd_cycles(100);
    chk(pops - base == 3, "R5 shortest lane limits output", pops - base, 3);
    chk(!m_valid, "R5 valid low with surplus on one lane", m_valid, 0);
    fork
      wr_burst(0, 2, 2);
      wr_burst(1, 2, 2);
      wr_burst(2, 2, 2);
    join
    rd_cycles(100);
    chk(pops - base == 5, "R6 surplus realigned", pops - base, 5);
    chk(!overflow, "R8 no false overflow", overflow, 0);

    // back-pressure and overflow
    @(posedge rd_clk); #1 m_ready = 1'b0;
    base = pops;
    fork
      wr_burst(0, 17, 16);
      wr_burst(1, 16, 16);
      wr_burst(2, 16, 16);
      wr_burst(3, 16, 16);
    join
    rd_cycles(100);
    chk(overflow, "R8 overflow set", overflow, 1);
    chk(m_valid, "R7 valid while stalled", m_valid, 1);
    held = m_data;
    chk(held[15:0] == q0[0], "R6 lane 0 in low bits", held[15:0], q0[0]);
    rd_cycles(10);
    chk(m_data == held && m_valid, "R7 data held under stall", m_data, held);
    chk(pops == base, "R7 nothing consumed under stall", pops - base, 0);
    @(posedge rd_clk); #1 m_ready = 1'b1;
    rd_cycles(100);
    chk(pops - base == 16, "R8 full lane kept 16 entries", pops - base, 16);
    chk(!m_valid && q0.size() == 0, "R8 dropped word absent", q0.size(), 0);
    chk(overflow, "R8 overflow sticky", overflow, 1);

    // intermittent ready
    base = pops;
    fork
      wr_burst(0, 30, 30);
      wr_burst(1, 30, 30);
      wr_burst(2, 30, 30);
      wr_burst(3, 30, 30);
      begin
        for (int k = 0; k < 400; k++) begin
          @(posedge rd_clk);
          #1 m_ready = (k % 3) != 0;
        end
        m_ready = 1'b1;
      end
    join
    rd_cycles(100);
    chk(pops - base == 30, "R7 all words delivered with gaps", pops - base, 30);
    chk(lane_up == 4'hF, "R4 lanes stay up", lane_up, 64'hF);

    // reset again clears state
    rd_rst_n = 1'b0;
    #10;
    chk(lane_up == 4'h0 && !m_valid && !overflow, "R1 reset clears overflow", {lane_up, m_valid, overflow}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule